// File: doc/BRIEF.md
# Dual-Clock Receive Word Buffer with Transfer Requests

This block sits between a serial protocol engine clocked by the receive clock and a transfer engine clocked by the system clock. Incoming bytes are packed into 32-bit words on the receive side. The words pass through a two-word clock-crossing stage into a fifteen-word main store on the system side. From there the block asks the downstream transfer engine to move the stored words out in one unbroken burst.

A request is raised on any of these conditions: the main store is full, a programmable byte threshold is reached, a word that closes a frame is stored, or a flush completes with data present. A flush comes either from a host pulse or from an optional timeout on the gap between characters. A not-empty status lets the host see whether any data is still pending anywhere in the path. Each drained word carries a count of its valid bytes and its frame-end flag.

The drain controller is a state machine with three states. DR_IDLE moves to DR_REQ on transition T_TRIGGER, when a trigger holds and words are stored. DR_REQ moves to DR_BURST on T_GRANT, when the grant pulse arrives. DR_BURST returns to DR_IDLE on T_LAST, after the final word. The flush controller has two states. FL_IDLE moves to FL_WAIT on T_FLUSH, when a host pulse or a timeout sends a close order to the packer. FL_WAIT returns to FL_IDLE on T_DONE, when the packer confirms that any partial word is now in the crossing stage.

Top module: `rxf_receive_buffer`

## Requirements
- R1: While the system-side reset is active and right after it, xfer_req, out_valid and stat_not_empty are all 0.
- R2: Bytes fill word lanes in arrival order, with the first byte in bits 7:0 and the fourth in bits 31:24. Lanes that were not filled read as zero. A word closes after four bytes, and out_nbytes reports its valid byte count from 1 to 4.
- R3: With cfg_thresh at 5, 6 or 7, a request comes only from a full store (15 words, 60 bytes), a stored frame-end word or a completed flush. Twelve bytes without a frame end raise no request.
- R4: A byte sent with rx_frame_end closes its word at once. That word leaves with out_frame_end set, and storing it raises a request.
- R5: The cfg_thresh codes 0, 1, 2, 3 and 4 request once the bytes held in the main store reach 1, 4, 8, 16 or 32. Code 0 also closes every byte as its own one-byte word.
- R6: A one-cycle host_flush pulse closes any partial word and raises a request if data is stored. A flush with nothing stored raises no request.
- R7: stat_not_empty is 1 whenever a byte is held in the packer, the crossing stage or the main store. It returns to 0 once a drain has emptied everything.
- R8: With cfg_tmo_en set, every received byte reloads a timer to cfg_tmo_cycles system cycles. When the timer expires it acts as a flush. An expiry with nothing stored raises no request.
- R9: xfer_req stays 1 from T_TRIGGER until the cycle of the last burst word, and it is 0 in the following cycle.
- R10: After a grant, out_valid is 1 for exactly N consecutive cycles, where N is the number of words stored at the grant. out_last is 1 only on the Nth word.
- R11: Words leave in the order their bytes arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive-side clock |
| rx_rst_n | input | 1 | Receive-side asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_frame_end | input | 1 | The present byte closes a frame |
| rx_overrun | output | 1 | Pulse: a closed word was lost because the crossing stage was full |
| sys_clk | input | 1 | System-side clock |
| sys_rst_n | input | 1 | System-side asynchronous reset, active low |
| cfg_thresh | input | 3 | Request threshold code (0:1 B, 1:4 B, 2:8 B, 3:16 B, 4:32 B, 5 to 7: full) |
| cfg_tmo_en | input | 1 | Enables the character-gap timeout |
| cfg_tmo_cycles | input | 16 | Timeout length in system cycles |
| host_flush | input | 1 | One-cycle flush command |
| stat_not_empty | output | 1 | Data is pending somewhere in the buffer |
| xfer_req | output | 1 | Transfer request toward the downstream buffer |
| xfer_grant | input | 1 | One-cycle grant that starts the burst |
| out_valid | output | 1 | A burst word is on the output |
| out_data | output | 32 | Burst word data |
| out_nbytes | output | 3 | Valid bytes in the burst word |
| out_frame_end | output | 1 | The burst word closes a frame |
| out_last | output | 1 | Final word of the burst |

## Verification
A lost or doubled word pointer shows up within one burst: a word comes out that no byte produced, comes out twice, or is missing, and the scoreboard sees this on the first affected word. A wrong byte or frame-end tally shows up as a request that comes too early, too late or not at all, and this is visible tens of system cycles after the stimulus, well inside each wait window. A stuck flush or timer state shows up as a missing request after the flush pulse, or as a request that appears when nothing is stored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int WORD_W = 32;
    localparam int NB_W   = 3;

    typedef struct packed {
        logic              fe;
        logic [NB_W-1:0]   nbytes;
        logic [WORD_W-1:0] data;
    } rxf_word_t;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_REQ   = 2'd1,
        DR_BURST = 2'd2
    } drain_state_t;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_WAIT = 1'b1
    } flush_state_t;

endpackage

// File: rtl/rxf_sync2.sv
module rxf_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/rxf_packer.sv
module rxf_packer
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_valid,
    input  logic [7:0] byte_data,
    input  logic      frame_end,
    input  logic      single_byte,
    input  logic      flush_tgl,
    input  logic      wr_full,
    output logic      wr_en,
    output rxf_word_t wr_word,
    output logic      overrun,
    output logic      byte_tgl,
    output logic      done_tgl,
    output logic      holding
);

    logic [NB_W-1:0]   nb;
    logic [NB_W-1:0]   nb_nx;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic              flush_prev;
    logic              flush_edge;
    logic              done_pend;
    logic              close;

    assign flush_edge = flush_tgl ^ flush_prev;

    always_comb begin
        merged = acc;
        if (byte_valid) begin
            merged[{nb[1:0], 3'b000} +: 8] = byte_data;
        end
    end

    assign nb_nx = nb + {{(NB_W-1){1'b0}}, byte_valid};

    assign close = (byte_valid && ((nb_nx == NB_W'(4)) || frame_end || single_byte))
                || (flush_edge && (nb_nx != '0));

    assign wr_en   = close;
    assign wr_word = '{fe: byte_valid & frame_end, nbytes: nb_nx, data: merged};
    assign overrun = close & wr_full;
    assign holding = (nb != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nb         <= '0;
            acc        <= '0;
            flush_prev <= 1'b0;
            done_pend  <= 1'b0;
            done_tgl   <= 1'b0;
            byte_tgl   <= 1'b0;
        end else begin
            flush_prev <= flush_tgl;
            done_pend  <= flush_edge;
            if (done_pend) begin
                done_tgl <= ~done_tgl;
            end
            if (byte_valid) begin
                byte_tgl <= ~byte_tgl;
            end
            if (close) begin
                nb  <= '0;
                acc <= '0;
            end else if (byte_valid) begin
                nb  <= nb_nx;
                acc <= merged;
            end
        end
    end

endmodule

// File: rtl/rxf_cdc_stage.sv
module rxf_cdc_stage
    import rxf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      wclk,
    input  logic      wrst_n,
    input  logic      wr_en,
    input  rxf_word_t wr_word,
    output logic      wr_full,
    input  logic      rclk,
    input  logic      rrst_n,
    input  logic      rd_en,
    output rxf_word_t rd_word,
    output logic      rd_empty
);

    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_MASK = PW'(3) << (PW - 2);

    rxf_word_t     mem [DEPTH];
    logic [PW-1:0] wbin, wgray, wbin_nx;
    logic [PW-1:0] rbin, rgray, rbin_nx;
    logic [PW-1:0] rgray_w, wgray_r;
    logic          push, pop;

    rxf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
    rxf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

    assign wr_full  = (wgray == (rgray_w ^ FULL_MASK));
    assign rd_empty = (rgray == wgray_r);
    assign push     = wr_en & ~wr_full;
    assign pop      = rd_en & ~rd_empty;
    assign wbin_nx  = wbin + PW'(1);
    assign rbin_nx  = rbin + PW'(1);
    assign rd_word  = mem[rbin[AW-1:0]];

    always_ff @(posedge wclk) begin
        if (push) begin
            mem[wbin[AW-1:0]] <= wr_word;
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

endmodule

// File: rtl/rxf_main_store.sv
module rxf_main_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 15,
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_empty,
    input  rxf_word_t         rd_word,
    output logic              rd_en,
    input  logic [2:0]        cfg_thresh,
    input  logic              cfg_tmo_en,
    input  logic [TMO_W-1:0]  cfg_tmo_cycles,
    input  logic              host_flush,
    input  logic              byte_tgl_s,
    input  logic              done_tgl_s,
    input  logic              holding_s,
    output logic              flush_tgl,
    output logic              not_empty,
    output logic              xfer_req,
    input  logic              xfer_grant,
    output logic              out_valid,
    output rxf_word_t         out_word,
    output logic              out_last
);

    localparam int PAW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int BW  = $clog2(DEPTH * 4 + 1);

    rxf_word_t      mem [DEPTH];
    logic [PAW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0]  count, fe_cnt, remain;
    logic [BW-1:0]  byte_cnt, thr_bytes;
    logic           thr_full;
    logic           push, pop;
    drain_state_t   dstate, dnext;
    flush_state_t   fstate, fnext;
    logic           flush_hold;
    logic           byte_prev, done_prev;
    logic           byte_edge, done_edge;
    logic [TMO_W-1:0] tmo_cnt;
    logic           tmo_armed, tmo_fire;
    logic           flush_go, trig;
    rxf_word_t      head;

    function automatic logic [PAW-1:0] ptr_inc(input logic [PAW-1:0] p);
        return (p == PAW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head      = mem[rd_ptr];
    assign byte_edge = byte_tgl_s ^ byte_prev;
    assign done_edge = done_tgl_s ^ done_prev;
    assign push      = ~rd_empty && (count < CW'(DEPTH));
    assign rd_en     = push;
    assign pop       = (dstate == DR_BURST);
    assign tmo_fire  = tmo_armed && cfg_tmo_en && !byte_edge && (tmo_cnt <= TMO_W'(1));
    assign flush_go  = host_flush | tmo_fire;

    always_comb begin
        thr_full  = 1'b0;
        thr_bytes = BW'(DEPTH * 4);
        unique case (cfg_thresh)
            3'd0:    thr_bytes = BW'(1);
            3'd1:    thr_bytes = BW'(4);
            3'd2:    thr_bytes = BW'(8);
            3'd3:    thr_bytes = BW'(16);
            3'd4:    thr_bytes = BW'(32);
            default: thr_full  = 1'b1;
        endcase
    end

    assign trig = (count != '0) &&
                  ((count == CW'(DEPTH)) ||
                   (!thr_full && (byte_cnt >= thr_bytes)) ||
                   (fe_cnt != '0) ||
                   flush_hold);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            fe_cnt   <= '0;
            byte_cnt <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            count    <= count + CW'(push) - CW'(pop);
            fe_cnt   <= fe_cnt + CW'(push & rd_word.fe) - CW'(pop & head.fe);
            byte_cnt <= byte_cnt + (push ? BW'(rd_word.nbytes) : '0)
                                 - (pop  ? BW'(head.nbytes)    : '0);
        end
    end

    always_comb begin
        dnext = dstate;
        unique case (dstate)
            DR_IDLE:  if (trig)               dnext = DR_REQ;
            DR_REQ:   if (xfer_grant)         dnext = DR_BURST;
            DR_BURST: if (remain == CW'(1))   dnext = DR_IDLE;
            default:                          dnext = DR_IDLE;
        endcase
    end

    always_comb begin
        fnext = fstate;
        unique case (fstate)
            FL_IDLE: if (flush_go)  fnext = FL_WAIT;
            FL_WAIT: if (done_edge) fnext = FL_IDLE;
            default:                fnext = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dstate <= DR_IDLE;
            fstate <= FL_IDLE;
        end else begin
            dstate <= dnext;
            fstate <= fnext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain     <= '0;
            flush_tgl  <= 1'b0;
            flush_hold <= 1'b0;
            byte_prev  <= 1'b0;
            done_prev  <= 1'b0;
            tmo_cnt    <= '0;
            tmo_armed  <= 1'b0;
        end else begin
            byte_prev <= byte_tgl_s;
            done_prev <= done_tgl_s;
            if (dstate == DR_REQ && xfer_grant) begin
                remain <= count;
            end else if (dstate == DR_BURST) begin
                remain <= remain - CW'(1);
            end
            if (fstate == FL_IDLE && flush_go) begin
                flush_tgl <= ~flush_tgl;
            end
            if (fstate == FL_WAIT && done_edge) begin
                flush_hold <= 1'b1;
            end else if (dstate == DR_IDLE && trig) begin
                flush_hold <= 1'b0;
            end else if (count == '0 && rd_empty) begin
                flush_hold <= 1'b0;
            end
            if (byte_edge) begin
                tmo_cnt   <= cfg_tmo_cycles;
                tmo_armed <= cfg_tmo_en;
            end else if (tmo_fire) begin
                tmo_armed <= 1'b0;
            end else if (tmo_armed) begin
                tmo_cnt <= tmo_cnt - TMO_W'(1);
            end
        end
    end

    always_comb begin
        xfer_req  = (dstate != DR_IDLE);
        out_valid = (dstate == DR_BURST);
        out_last  = (dstate == DR_BURST) && (remain == CW'(1));
        out_word  = head;
        not_empty = (count != '0) || !rd_empty || holding_s;
    end

endmodule

// File: rtl/rxf_receive_buffer.sv
module rxf_receive_buffer
    import rxf_pkg::*;
#(
    parameter int MAIN_DEPTH = 15,
    parameter int CDC_DEPTH  = 2,
    parameter int TMO_W      = 16
) (
    input  logic             rx_clk,
    input  logic             rx_rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_frame_end,
    output logic             rx_overrun,
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic [2:0]       cfg_thresh,
    input  logic             cfg_tmo_en,
    input  logic [TMO_W-1:0] cfg_tmo_cycles,
    input  logic             host_flush,
    output logic             stat_not_empty,
    output logic             xfer_req,
    input  logic             xfer_grant,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic [2:0]       out_nbytes,
    output logic             out_frame_end,
    output logic             out_last
);

    rxf_word_t pk_word, cdc_word, out_word;
    logic      pk_wr, cdc_full, cdc_empty, cdc_rd;
    logic      byte_tgl, done_tgl, holding;
    logic      byte_tgl_s, done_tgl_s, holding_s;
    logic      flush_tgl, flush_tgl_r;
    logic      single_byte;

    assign single_byte = (cfg_thresh == 3'd0);

    rxf_sync2 #(.W(1)) u_flush_sync (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(flush_tgl), .q(flush_tgl_r)
    );

    rxf_sync2 #(.W(3)) u_stat_sync (
        .clk(sys_clk), .rst_n(sys_rst_n),
        .d({byte_tgl, done_tgl, holding}),
        .q({byte_tgl_s, done_tgl_s, holding_s})
    );

    rxf_packer u_packer (
        .clk(rx_clk), .rst_n(rx_rst_n),
        .byte_valid(rx_valid), .byte_data(rx_data), .frame_end(rx_frame_end),
        .single_byte(single_byte), .flush_tgl(flush_tgl_r), .wr_full(cdc_full),
        .wr_en(pk_wr), .wr_word(pk_word), .overrun(rx_overrun),
        .byte_tgl(byte_tgl), .done_tgl(done_tgl), .holding(holding)
    );

    rxf_cdc_stage #(.DEPTH(CDC_DEPTH)) u_cdc (
        .wclk(rx_clk), .wrst_n(rx_rst_n), .wr_en(pk_wr), .wr_word(pk_word), .wr_full(cdc_full),
        .rclk(sys_clk), .rrst_n(sys_rst_n), .rd_en(cdc_rd), .rd_word(cdc_word), .rd_empty(cdc_empty)
    );

    rxf_main_store #(.DEPTH(MAIN_DEPTH), .TMO_W(TMO_W)) u_main (
        .clk(sys_clk), .rst_n(sys_rst_n),
        .rd_empty(cdc_empty), .rd_word(cdc_word), .rd_en(cdc_rd),
        .cfg_thresh(cfg_thresh), .cfg_tmo_en(cfg_tmo_en), .cfg_tmo_cycles(cfg_tmo_cycles),
        .host_flush(host_flush),
        .byte_tgl_s(byte_tgl_s), .done_tgl_s(done_tgl_s), .holding_s(holding_s),
        .flush_tgl(flush_tgl), .not_empty(stat_not_empty),
        .xfer_req(xfer_req), .xfer_grant(xfer_grant),
        .out_valid(out_valid), .out_word(out_word), .out_last(out_last)
    );

    assign out_data      = out_word.data;
    assign out_nbytes    = out_word.nbytes;
    assign out_frame_end = out_word.fe;

endmodule

module rxf_receive_buffer_chk (
    input logic       sys_clk,
    input logic       sys_rst_n,
    input logic       xfer_req,
    input logic       xfer_grant,
    input logic       out_valid,
    input logic       out_last,
    input logic [2:0] out_nbytes,
    input logic       stat_not_empty
);

    always @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            p_reset_quiet_r1: assert (!xfer_req && !out_valid && !stat_not_empty)
                else $error("reset state not quiet");
        end
    end

    p_nbytes_range_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        out_valid |-> (out_nbytes != 3'd0 && out_nbytes <= 3'd4));

    p_req_has_data_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        xfer_req |-> stat_not_empty);

    p_req_held_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (xfer_req && !(out_valid && out_last)) |=> xfer_req);

    p_req_drops_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (out_valid && out_last) |=> !xfer_req);

    p_valid_in_req_r10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        out_valid |-> xfer_req);

    p_burst_contig_r10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (out_valid && !out_last) |=> out_valid);

    p_burst_start_r10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(out_valid) |-> $past(xfer_grant));

endmodule

bind rxf_receive_buffer rxf_receive_buffer_chk u_rxf_chk (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .xfer_req(xfer_req),
    .xfer_grant(xfer_grant), .out_valid(out_valid), .out_last(out_last),
    .out_nbytes(out_nbytes), .stat_not_empty(stat_not_empty)
);

// File: tb/test_rxf_receive_buffer.sv
module test_rxf_receive_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int RX_PERIOD  = 14;

    logic        rx_clk = 1'b0, sys_clk = 1'b0;
    logic        rx_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_frame_end = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_overrun;
    logic [2:0]  cfg_thresh = 3'd5;
    logic        cfg_tmo_en = 1'b0;
    logic [15:0] cfg_tmo_cycles = 16'd50;
    logic        host_flush = 1'b0, xfer_grant = 1'b0;
    logic        stat_not_empty, xfer_req, out_valid, out_frame_end, out_last;
    logic [31:0] out_data;
    logic [2:0]  out_nbytes;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
    always #(RX_PERIOD/2)  rx_clk  = ~rx_clk;

    rxf_receive_buffer i_rxf_receive_buffer (
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_end(rx_frame_end), .rx_overrun(rx_overrun),
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_thresh(cfg_thresh),
        .cfg_tmo_en(cfg_tmo_en), .cfg_tmo_cycles(cfg_tmo_cycles), .host_flush(host_flush),
        .stat_not_empty(stat_not_empty), .xfer_req(xfer_req), .xfer_grant(xfer_grant),
        .out_valid(out_valid), .out_data(out_data), .out_nbytes(out_nbytes),
        .out_frame_end(out_frame_end), .out_last(out_last)
    );

    typedef struct { logic [31:0] d; int nb; bit fe; } exp_t;
    exp_t        exp_q[$];
    int          checks = 0, errors = 0, burst_left = 0;
    logic [31:0] m_data = '0;
    int          m_nb = 0;
    bit          m_single = 1'b0;
    logic [7:0]  next_val = 8'h10;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_close(input bit fe);
        exp_t e;
        if (m_nb > 0) begin
            e.d = m_data; e.nb = m_nb; e.fe = fe;
            exp_q.push_back(e);
        end
        m_data = '0;
        m_nb = 0;
    endtask

    task automatic send_byte(input bit fe);
        @(negedge rx_clk);
        rx_valid = 1'b1; rx_data = next_val; rx_frame_end = fe;
        m_data[8*m_nb +: 8] = next_val;
        m_nb++;
        next_val = next_val + 8'd7;
        if (m_nb == 4 || fe || m_single) model_close(fe);
        @(negedge rx_clk);
        rx_valid = 1'b0; rx_frame_end = 1'b0;
    endtask

    task automatic send_n(input int n, input bit fe_last);
        for (int i = 0; i < n; i++) send_byte(fe_last && (i == n - 1));
    endtask

    task automatic sys_wait(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic flush_pulse();
        @(negedge sys_clk); host_flush = 1'b1;
        @(negedge sys_clk); host_flush = 1'b0;
    endtask

    // scoreboard monitor: words in arrival order (R2, R11), last flag per burst (R10)
    always @(negedge sys_clk) begin
        if (sys_rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected word", out_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data == e.d, "R2,R11", "data", out_data, e.d);
                check(out_nbytes == 3'(e.nb), "R2", "nbytes", out_nbytes, e.nb);
                check(out_frame_end == e.fe, "R4", "frame end", out_frame_end, e.fe);
                check(out_last == (burst_left == 1), "R10", "last flag", out_last, burst_left == 1);
                burst_left--;
            end
        end
    end

    task automatic drain(input string req);
        int n;
        n = 0;
        while (!xfer_req && n < 200) begin
            @(negedge sys_clk); n++;
        end
        check(xfer_req == 1'b1, req, "request raised", xfer_req, 1);
        if (xfer_req) begin
            burst_left = exp_q.size();
            @(negedge sys_clk); xfer_grant = 1'b1;
            @(negedge sys_clk); xfer_grant = 1'b0;
            n = 0;
            while (burst_left > 0 && n < 100) begin
                @(posedge sys_clk); n++;
            end
            @(negedge sys_clk);
            check(burst_left == 0, "R10", "words left in burst", burst_left, 0);
            check(xfer_req == 1'b0, "R9", "request after last", xfer_req, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int drops;
        sys_wait(5);
        check(!xfer_req && !out_valid && !stat_not_empty, "R1", "outputs in reset",
              {xfer_req, out_valid, stat_not_empty}, 0);
        rx_rst_n = 1'b1; sys_rst_n = 1'b1;
        sys_wait(4);
        check(!xfer_req && !out_valid && !stat_not_empty, "R1", "outputs after reset",
              {xfer_req, out_valid, stat_not_empty}, 0);

        // R3: default threshold, 12 bytes, no request
        send_n(12, 1'b0);
        sys_wait(40);
        check(xfer_req == 1'b0, "R3", "no request below full", xfer_req, 0);
        check(stat_not_empty == 1'b1, "R7", "not empty with data", stat_not_empty, 1);
        // R3: fill to 15 words
        send_n(48, 1'b0);
        drain("R3");
        sys_wait(10);
        check(stat_not_empty == 1'b0, "R7", "empty after drain", stat_not_empty, 0);

        // R4 + R9: frame end, request held while grant is delayed
        send_n(5, 1'b1);
        sys_wait(40);
        check(xfer_req == 1'b1, "R4", "frame end request", xfer_req, 1);
        drops = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge sys_clk);
            if (!xfer_req) drops++;
        end
        check(drops == 0, "R9", "request held before grant", drops, 0);
        drain("R4");

        // R5: 8-byte threshold
        cfg_thresh = 3'd2;
        send_n(7, 1'b0);
        sys_wait(40);
        check(xfer_req == 1'b0, "R5", "below 8 bytes", xfer_req, 0);
        send_n(1, 1'b0);
        drain("R5");

        // R5: single-byte threshold
        cfg_thresh = 3'd0; m_single = 1'b1;
        send_n(1, 1'b0);
        drain("R5");
        cfg_thresh = 3'd5; m_single = 1'b0;

        // R6: host flush with partial word
        send_n(5, 1'b0);
        sys_wait(40);
        check(xfer_req == 1'b0, "R6", "no request before flush", xfer_req, 0);
        check(stat_not_empty == 1'b1, "R7", "partial word pending", stat_not_empty, 1);
        model_close(1'b0);
        flush_pulse();
        drain("R6");

        // R6: flush with nothing stored
        flush_pulse();
        sys_wait(80);
        check(xfer_req == 1'b0, "R6", "empty flush no request", xfer_req, 0);

        // R8: timeout reloaded by each byte, then expires
        cfg_tmo_en = 1'b1; cfg_tmo_cycles = 16'd50;
        send_n(1, 1'b0); sys_wait(35);
        send_n(1, 1'b0); sys_wait(35);
        send_n(1, 1'b0); sys_wait(20);
        check(xfer_req == 1'b0, "R8", "timer reloaded by bytes", xfer_req, 0);
        model_close(1'b0);
        drain("R8");

        // R8: expiry after everything drained gives no request
        cfg_thresh = 3'd0; m_single = 1'b1;
        send_n(1, 1'b0);
        drain("R8");
        sys_wait(150);
        check(xfer_req == 1'b0, "R8", "empty expiry no request", xfer_req, 0);
        check(exp_q.size() == 0, "R8", "no stray words", exp_q.size(), 0);
        cfg_tmo_en = 1'b0; cfg_thresh = 3'd5; m_single = 1'b0;

        sys_wait(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule